// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, frame by frame, whether a receiver should keep an incoming Ethernet frame. It looks only at the 6-byte destination address, which arrives one byte per valid cycle, first byte on the wire first. One cycle after the sixth byte it raises a one-cycle done strobe. An accept flag comes with the strobe.

Four classes of destination are recognised. A promiscuous mode takes everything. The all-ones broadcast address and group (multicast) addresses are each gated by their own mode bit. Multicast acceptance also needs a hit in a 64-bit hash table, indexed by six bits of a CRC-32 of the address. Any other (individual) address must equal the programmed station address exactly. The station address, the hash table and the mode bits are all loaded through a write-only byte register port. The CRC engine is part of the block.

Top module: `eth_dest_filter`

## Requirements
- R1: After reset, `match_done` and `match_accept` are 0 and the station address, hash table and mode bits are all zero.
- R2: A register write stores `reg_wdata` at `reg_addr`. Addresses 0..5 hold station bytes 0..5, where byte 0 is compared with the first destination byte. Addresses 8..15 hold hash table bytes 0..7. Address 16 holds the mode byte.
- R3: Bytes are counted only in cycles where `dst_valid` is high, and gaps between bytes are allowed. In the cycle after the sixth counted byte, `match_done` is high for exactly one cycle. The next frame starts with the next valid byte.
- R4: When mode bit 4 (promiscuous) is set, every frame is accepted.
- R5: Otherwise, a destination of all ones (FF on all six bytes) is accepted exactly when mode bit 2 is set.
- R6: Otherwise, a destination whose first byte has bit 0 set is a group address. It is rejected whenever mode bit 3 is clear.
- R7: The hash index of a group address is bits 31..26 of a CRC-32. The CRC uses polynomial 0x04C11DB7 and starts from all ones. It shifts left and takes the six bytes in wire order, each byte least-significant bit first. There is no final inversion.
- R8: With mode bit 3 set, a group address is accepted exactly when hash table byte (index >> 3), bit (index & 7) is 1.
- R9: Any other destination is accepted exactly when all six bytes equal station bytes 0..5.
- R10: Writes to register addresses outside 0..5, 8..15 and 16 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| dst_valid | input | 1 | Destination byte valid |
| dst_byte | input | 8 | Destination byte, wire order |
| match_done | output | 1 | One-cycle strobe: decision ready |
| match_accept | output | 1 | Accept (1) or reject (0), valid with `match_done` |

## Verification
Directed frames cover the following cases:
- A station address that matches in full.
- A station address that differs only in its last byte, which separates a full six-byte compare from a partial one.
- Broadcast and group addresses under each setting of their mode bits.
- Group addresses against a table that holds only the indexed bit, only its neighbour, or every bit but the indexed one. These cases tell a correct CRC and bit selection apart from an off-by-one index or a swapped byte order.

Random frames are then drawn from a mix of random, station-copy, broadcast and group addresses, with random modes and tables. The same frames are also sent with idle gaps between bytes, to separate counting of valid bytes from counting of cycles. A write to an unmapped address that would turn on promiscuous mode, if it were decoded, must leave a mismatching frame rejected.

// File: rtl/af_pkg.sv
// Package: shared constants and types for the destination address filter.
// Assumes an 8-bit register port and byte-serial destination input.
package af_pkg;

    // CRC-32 generator polynomial used for the multicast hash.
    localparam logic [31:0] AF_CRC_POLY = 32'h04C11DB7;

    // Register map bases (station, hash table, mode byte).
    localparam int AF_STA_BASE  = 0;
    localparam int AF_HASH_BASE = 8;
    localparam int AF_MODE_ADDR = 16;

    // Bit positions inside the mode byte.
    localparam int AF_BIT_BCAST   = 2;
    localparam int AF_BIT_MCAST   = 3;
    localparam int AF_BIT_PROMISC = 4;

    // Decoded acceptance modes.
    typedef struct packed {
        logic promisc;
        logic mcast;
        logic bcast;
    } af_mode_t;

endpackage

// File: rtl/af_crc32_byte.sv
// Module: af_crc32_byte
// Combinational CRC-32 update for one byte, processed least-significant bit
// first with a left-shifting register. Assumes the caller holds the state.
module af_crc32_byte #(
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  logic [31:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [31:0] crc_out
);

    logic [31:0] stage [9];

    assign stage[0] = crc_in;

    // One shift/xor stage per data bit, LSB first.
    for (genvar i = 0; i < 8; i++) begin : g_bit
        logic fb;
        assign fb = stage[i][31] ^ data_in[i];
        assign stage[i+1] = {stage[i][30:0], 1'b0} ^ ({32{fb}} & POLY);
    end

    assign crc_out = stage[8];

endmodule

// File: rtl/af_regbank.sv
// Module: af_regbank
// Write-only register bank holding the station address, the multicast hash
// table and the mode byte. Assumes single-cycle byte writes; unmapped
// addresses are dropped.
module af_regbank
    import af_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 64,
    parameter int REG_AW     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [7:0]              reg_wdata,
    output logic [8*ADDR_BYTES-1:0] station,
    output logic [HASH_BITS-1:0]    hash_tbl,
    output af_mode_t                mode
);

    localparam int HASH_BYTES = HASH_BITS / 8;
    localparam logic [REG_AW-1:0] MODE_A = REG_AW'(AF_MODE_ADDR);

    // Station address bytes, one register per byte.
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_sta
        localparam logic [REG_AW-1:0] MY_A = REG_AW'(AF_STA_BASE + i);
        // Load station byte i on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                station[8*i +: 8] <= '0;
            else if (reg_we && reg_addr == MY_A)
                station[8*i +: 8] <= reg_wdata;
        end

        p_station_write_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == MY_A) |=> (station[8*i +: 8] == $past(reg_wdata)));
    end

    // Hash table bytes, one register per byte.
    for (genvar j = 0; j < HASH_BYTES; j++) begin : g_hash
        localparam logic [REG_AW-1:0] MY_A = REG_AW'(AF_HASH_BASE + j);
        // Load hash byte j on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hash_tbl[8*j +: 8] <= '0;
            else if (reg_we && reg_addr == MY_A)
                hash_tbl[8*j +: 8] <= reg_wdata;
        end
    end

    // Mode byte: only the three decoded bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= '0;
        else if (reg_we && reg_addr == MODE_A) begin
            mode.promisc <= reg_wdata[AF_BIT_PROMISC];
            mode.mcast   <= reg_wdata[AF_BIT_MCAST];
            mode.bcast   <= reg_wdata[AF_BIT_BCAST];
        end
    end

    p_mode_write_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == MODE_A) |=> (mode.promisc == $past(reg_wdata[AF_BIT_PROMISC])));

    p_mode_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == MODE_A) |=> $stable(mode));

endmodule

// File: rtl/af_classify.sv
// Module: af_classify
// Counts destination bytes, runs the CRC, tracks broadcast/station-match
// state and issues the accept decision one cycle after the last byte.
// Assumes register contents are stable during a frame.
module af_classify
    import af_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dst_valid,
    input  logic [7:0]              dst_byte,
    input  logic [8*ADDR_BYTES-1:0] station,
    input  logic [HASH_BITS-1:0]    hash_tbl,
    input  af_mode_t                mode,
    output logic                    done,
    output logic                    accept
);

    localparam int CW  = $clog2(ADDR_BYTES);
    localparam int HIW = $clog2(HASH_BITS);
    localparam logic [CW-1:0] LAST_CNT = CW'(ADDR_BYTES - 1);

    logic [CW-1:0] cnt_q;
    logic [31:0]   crc_q, crc_seed, crc_nxt;
    logic          ones_q, ones_nxt;
    logic          eq_q, eq_nxt;
    logic          grp_q, grp_nxt;
    logic          first, last;
    logic [7:0]    sta_byte;
    logic [HIW-1:0] hash_idx;
    logic          verdict;

    assign first = (cnt_q == '0);
    assign last  = (cnt_q == LAST_CNT);

    // Station byte aligned with the current position.
    always_comb begin
        sta_byte = 8'(station >> {cnt_q, 3'b000});
    end

    assign crc_seed = first ? '1 : crc_q;

    af_crc32_byte #(.POLY(AF_CRC_POLY)) u_crc (
        .crc_in  (crc_seed),
        .data_in (dst_byte),
        .crc_out (crc_nxt)
    );

    // Running flags including the byte on the input now.
    always_comb begin
        ones_nxt = (first ? 1'b1 : ones_q) & (dst_byte == 8'hFF);
        eq_nxt   = (first ? 1'b1 : eq_q) & (dst_byte == sta_byte);
        grp_nxt  = first ? dst_byte[0] : grp_q;
        hash_idx = crc_nxt[31 -: HIW];
    end

    // Priority decision: promiscuous, broadcast, group, individual.
    always_comb begin
        if (mode.promisc)
            verdict = 1'b1;
        else if (ones_nxt)
            verdict = mode.bcast;
        else if (grp_nxt)
            verdict = mode.mcast & hash_tbl[hash_idx];
        else
            verdict = eq_nxt;
    end

    // Per-byte state update and decision register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            crc_q  <= '1;
            ones_q <= 1'b0;
            eq_q   <= 1'b0;
            grp_q  <= 1'b0;
            done   <= 1'b0;
            accept <= 1'b0;
        end else begin
            done <= 1'b0;
            if (dst_valid) begin
                cnt_q  <= last ? '0 : cnt_q + 1'b1;
                crc_q  <= crc_nxt;
                ones_q <= ones_nxt;
                eq_q   <= eq_nxt;
                grp_q  <= grp_nxt;
                if (last) begin
                    done   <= 1'b1;
                    accept <= verdict;
                end
            end
        end
    end

    p_done_after_last_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(dst_valid && last));

    p_done_single_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_count_range_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    p_promisc_accept_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mode.promisc)) |-> accept);

    p_bcast_gate_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(!mode.promisc && ones_nxt)) |-> (accept == $past(mode.bcast)));

    p_mcast_gate_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(!mode.promisc && !ones_nxt && grp_nxt && !mode.mcast)) |-> !accept);

endmodule

// File: rtl/eth_dest_filter.sv
// Module: eth_dest_filter (top)
// Destination address filter: register bank plus byte-serial classifier.
// Assumes destination bytes arrive in wire order with a valid strobe.
module eth_dest_filter
    import af_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 64,
    parameter int REG_AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              dst_valid,
    input  logic [7:0]        dst_byte,
    output logic              match_done,
    output logic              match_accept
);

    logic [8*ADDR_BYTES-1:0] station;
    logic [HASH_BITS-1:0]    hash_tbl;
    af_mode_t                mode;

    af_regbank #(
        .ADDR_BYTES (ADDR_BYTES),
        .HASH_BITS  (HASH_BITS),
        .REG_AW     (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .station   (station),
        .hash_tbl  (hash_tbl),
        .mode      (mode)
    );

    af_classify #(
        .ADDR_BYTES (ADDR_BYTES),
        .HASH_BITS  (HASH_BITS)
    ) u_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .dst_valid (dst_valid),
        .dst_byte  (dst_byte),
        .station   (station),
        .hash_tbl  (hash_tbl),
        .mode      (mode),
        .done      (match_done),
        .accept    (match_accept)
    );

    p_reset_quiet_r1 : assert property (@(posedge clk)
        !rst_n |=> (!match_done && !match_accept));

endmodule

// File: tb/eth_dest_filter_tb_top.sv
// Bench: directed corner cases plus seeded random frames, checked against
// a model built from the requirements.
module eth_dest_filter_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       dst_valid = 1'b0;
    logic [7:0] dst_byte = '0;
    logic       match_done, match_accept;

    int total = 0;
    int bad = 0;

    // Bench copy of the programmed state.
    logic [47:0] m_sta = '0;
    logic [63:0] m_tbl = '0;
    logic [7:0]  m_mode = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_dest_filter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .dst_valid    (dst_valid),
        .dst_byte     (dst_byte),
        .match_done   (match_done),
        .match_accept (match_accept)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // R7: hash index from the stated CRC definition.
    function automatic logic [5:0] m_hash(input logic [47:0] a);
        logic [31:0] c = '1;
        for (int k = 0; k < 6; k++)
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[31] ^ a[8*k+b];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C11DB7;
            end
        return c[31:26];
    endfunction

    function automatic logic m_accept(input logic [47:0] a);
        if (m_mode[4]) return 1'b1;
        if (a == '1) return m_mode[2];
        if (a[0]) return m_mode[3] & m_tbl[m_hash(a)];
        return a == m_sta;
    endfunction

    function automatic string m_class(input logic [47:0] a);
        if (m_mode[4]) return "R4";
        if (a == '1) return "R5";
        if (a[0]) return m_mode[3] ? "R8" : "R6";
        return "R9";
    endfunction

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_station(input logic [47:0] s);
        for (int i = 0; i < 6; i++) wr(5'(i), s[8*i +: 8]);
        m_sta = s;
    endtask

    task automatic set_table(input logic [63:0] t);
        for (int i = 0; i < 8; i++) wr(5'(8 + i), t[8*i +: 8]);
        m_tbl = t;
    endtask

    task automatic set_mode(input logic [7:0] m);
        wr(5'd16, m);
        m_mode = m;
    endtask

    // Send one address (byte 0 first), with optional idle gaps, and check.
    task automatic frame(input logic [47:0] a, input int gap, input string req);
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            dst_valid = 1'b1; dst_byte = a[8*i +: 8];
            @(negedge clk);
            if (i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    dst_valid = 1'b0; dst_byte = 8'hA5;
                    check("R3 no early done", match_done, 1'b0);
                    @(negedge clk);
                end
                check("R3 no early done", match_done, 1'b0);
            end
        end
        dst_valid = 1'b0;
        check("R3 done after sixth byte", match_done, 1'b1);
        check(req, match_accept, m_accept(a));
        @(negedge clk);
        check("R3 done one cycle", match_done, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [47:0] a;
        logic [5:0]  h;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 done after reset", match_done, 1'b0);
        check("R1 accept after reset", match_accept, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done idle", match_done, 1'b0);

        // R1/R9: zero station after reset matches an all-zero address.
        frame(48'h0, 0, "R1 zero station");
        frame(48'h0000_0000_0200, 0, "R9 reset station mismatch");

        // R2/R9: programmed station, full and last-byte mismatch.
        set_station(48'h5544_3322_1100);
        frame(48'h5544_3322_1100, 0, "R9 exact match");
        frame(48'h5644_3322_1100, 0, "R9 last byte differs");
        frame(48'h5544_3322_1102, 1, "R9 first byte differs");

        // R5: broadcast gated by bit 2.
        set_mode(8'h00);
        frame('1, 0, "R5 broadcast off");
        set_mode(8'h04);
        frame('1, 2, "R5 broadcast on");

        // R6: group address rejected without bit 3 even with full table.
        set_table('1);
        set_mode(8'h00);
        frame(48'h0000_005E_0001, 0, "R6 group off");

        // R7/R8: only the indexed bit, only its neighbour, all but indexed.
        a = 48'h0102_035E_0001;
        h = m_hash(a);
        set_mode(8'h08);
        set_table(64'h1 << h);
        frame(a, 0, "R7 indexed bit set");
        set_table(64'h1 << (h ^ 6'd1));
        frame(a, 0, "R8 neighbour bit only");
        set_table(~(64'h1 << h));
        frame(a, 0, "R8 all but indexed");
        set_table(64'h1 << (h ^ 6'd8));
        frame(a, 0, "R8 other byte same bit");

        // R4: promiscuous takes a mismatching individual address.
        set_mode(8'h10);
        frame(48'hDEAD_BEEF_0000, 0, "R4 promiscuous");

        // R10: unmapped write that would set promiscuous if decoded.
        set_mode(8'h00);
        wr(5'd17, 8'h1C);
        wr(5'd6, 8'hFF);
        wr(5'd31, 8'h1C);
        frame(48'hDEAD_BEEF_0000, 0, "R10 unmapped write ignored");
        frame(48'h5544_3322_1100, 0, "R10 station intact");

        // Seeded random frames.
        for (int n = 0; n < 400; n++) begin
            int kind;
            if (n % 25 == 0) begin
                set_mode(8'($urandom));
                set_table({$urandom, $urandom});
                if (n % 50 == 0) set_station({16'($urandom), $urandom} & ~48'h1);
            end
            kind = $urandom_range(0, 4);
            case (kind)
                0: a = {16'($urandom), $urandom};
                1: a = m_sta;
                2: a = '1;
                3: a = {16'($urandom), $urandom} | 48'h1;
                default: a = m_sta ^ (48'h1 << (8 * $urandom_range(0, 5) + 1));
            endcase
            frame(a, (n % 7 == 0) ? 1 : 0, m_class(a));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule